// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Memory Loader

This block sits between a host register set and a small external byte-wide EEPROM. It lets the host read or write a single EEPROM byte through an address register and an 8-bit data register. It also runs a burst mode that walks the EEPROM as a stream of records and copies each record's payload into device memory through a write port with a 24-bit address.

Each burst record starts with a 16-bit address sent low byte first, then a one-byte count N, then N payload bytes. A count of zero ends the burst. Only the low 15 bits of the record address are used, and they are incremented for each payload byte. A 9-bit base register supplies memory address bits [23:15].

An EEPROM pointer is kept across operations. After reset it is 0. After any transferred byte it holds the address after that byte, so a burst resumes where the last access left off. Requests are flagged by setting bits. A request raised while another operation runs stays pending and is served later.

Top module: `eeprom_loader`

## Requirements
- R1: After reset the control register (select 0) and the burst register (select 4) read 0, `ee_req` is low and `mem_we` is low.
- R2: Writing control bit 1 (select 0) reads the EEPROM at the address register (select 1), loads the byte into the data register (select 2), and clears bit 1 when the byte arrives.
- R3: Writing control bit 0 writes the data register byte to the EEPROM at the address register with `ee_we` high, and clears bit 0 when the EEPROM reports done.
- R4: The data register holds 8 bits. A host write keeps only `hw_wdata[7:0]`, and its read value has bits [31:8] at zero.
- R5: A burst started (bit 0 of select 4) after reset, before any single access, fetches its first byte from EEPROM address 0.
- R6: A burst fetches its first byte from the address after the last EEPROM byte transferred, whether that byte came from a single access or a burst.
- R7: A burst reads records of the form address low byte, address high byte, count N, then N payload bytes. It ends after a record with N = 0, and the burst bit then reads 0.
- R8: Each payload byte is written to memory at `{base[8:0], offset[14:0]}`. The offset starts at the record address with bit 15 dropped and increments by one per byte, wrapping within 15 bits. The base is at select 3.
- R9: Only one EEPROM access runs at a time. `ee_addr` is held until `ee_done`. Pending requests are served in the order read, then write, then burst.
- R10: Writing 0 to a control bit has no effect; a pending or running request is not cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 3 | Host write register select |
| hw_wdata | input | 32 | Host write data |
| hr_sel | input | 3 | Host read register select |
| hr_data | output | 32 | Host read data (combinational) |
| ee_req | output | 1 | EEPROM byte access request, held until done |
| ee_we | output | 1 | EEPROM access is a write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdata | input | 8 | EEPROM read byte, valid with done |
| ee_done | input | 1 | One-cycle access completion |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The bench attacks the pointer history: a burst straight after reset, a burst after a single read, and a burst after another burst. A design that always restarts at 0, or forgets the count bytes when advancing, would fetch the wrong record. Record addresses have bit 15 set and sit at the 15-bit top, so a design that keeps that bit or carries into the base would corrupt `mem_addr`. Overlapping read, write and burst requests, plus a 0 written over a pending bit, expose a wrong service order or a cancelled request in the EEPROM access log.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SGL, ST_BURST} eng_st_t;
  typedef enum logic [1:0] {PH_ALO, PH_AHI, PH_LEN, PH_DAT} rec_ph_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ADDR  = 3'd1;
  localparam logic [2:0] SEL_DATA  = 3'd2;
  localparam logic [2:0] SEL_BASE  = 3'd3;
  localparam logic [2:0] SEL_BURST = 3'd4;

  localparam int BASE_W = 9;
  localparam int OFF_W  = 15;
  localparam int MA_W   = BASE_W + OFF_W;

  function automatic logic [MA_W-1:0] burst_mem_addr(input logic [BASE_W-1:0] base,
                                                     input logic [OFF_W-1:0] off);
    return {base, off};
  endfunction

  function automatic logic [OFF_W-1:0] rec_offset(input logic [6:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/eeb_hostregs.sv
module eeb_hostregs
  import eeb_pkg::*;
#(
  parameter int HW    = 32,
  parameter int EE_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [2:0]        hw_sel,
  input  logic [HW-1:0]     hw_wdata,
  input  logic [2:0]        hr_sel,
  output logic [HW-1:0]     hr_data,
  input  logic              rd_fin,
  input  logic              wr_fin,
  input  logic              bu_fin,
  input  logic [7:0]        rd_byte,
  output logic              rd_pend,
  output logic              wr_pend,
  output logic              bu_pend,
  output logic [EE_AW-1:0]  addr_q,
  output logic [7:0]        data_q,
  output logic [BASE_W-1:0] base_q
);
  logic rd_set, wr_set, bu_set;

  assign rd_set = hw_en && hw_sel == SEL_CTRL && hw_wdata[1];
  assign wr_set = hw_en && hw_sel == SEL_CTRL && hw_wdata[0];
  assign bu_set = hw_en && hw_sel == SEL_BURST && hw_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      bu_pend <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
    end else begin
      rd_pend <= rd_set | (rd_pend & ~rd_fin);
      wr_pend <= wr_set | (wr_pend & ~wr_fin);
      bu_pend <= bu_set | (bu_pend & ~bu_fin);
      if (hw_en && hw_sel == SEL_ADDR) addr_q <= hw_wdata[EE_AW-1:0];
      if (hw_en && hw_sel == SEL_BASE) base_q <= hw_wdata[BASE_W-1:0];
      if (rd_fin) data_q <= rd_byte;
      else if (hw_en && hw_sel == SEL_DATA) data_q <= hw_wdata[7:0];
    end
  end

  always_comb begin
    hr_data = '0;
    case (hr_sel)
      SEL_CTRL:  hr_data[1:0] = {rd_pend, wr_pend};
      SEL_ADDR:  hr_data[EE_AW-1:0] = addr_q;
      SEL_DATA:  hr_data[7:0] = data_q;
      SEL_BASE:  hr_data[BASE_W-1:0] = base_q;
      SEL_BURST: hr_data[0] = bu_pend;
      default:   hr_data = '0;
    endcase
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fin && !rd_set) |=> !rd_pend); // R2
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fin && !wr_set) |=> !wr_pend); // R3
  AST_BU_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bu_fin && !bu_set) |=> !bu_pend); // R7
  AST_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !rd_fin) |=> rd_pend); // R10
endmodule

// File: rtl/eeb_engine.sv
module eeb_engine
  import eeb_pkg::*;
#(
  parameter int EE_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pend,
  input  logic              wr_pend,
  input  logic              bu_pend,
  input  logic [EE_AW-1:0]  addr_q,
  input  logic [7:0]        data_q,
  input  logic [BASE_W-1:0] base_q,
  output logic              rd_fin,
  output logic              wr_fin,
  output logic              bu_fin,
  output logic [7:0]        rd_byte,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic [7:0]        ee_rdata,
  input  logic              ee_done,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata
);
  eng_st_t           st;
  rec_ph_t           ph;
  logic              is_wr;
  logic [EE_AW-1:0]  cur, ptr;
  logic [BASE_W-1:0] base_l;
  logic [OFF_W-1:0]  off;
  logic [7:0]        cnt, wbyte;
  logic              byte_in;

  assign byte_in  = ee_done && st == ST_BURST;
  assign rd_fin   = ee_done && st == ST_SGL && !is_wr;
  assign wr_fin   = ee_done && st == ST_SGL && is_wr;
  assign bu_fin   = byte_in && ph == PH_LEN && ee_rdata == 8'd0;
  assign rd_byte  = ee_rdata;
  assign ee_req   = st != ST_IDLE;
  assign ee_we    = st == ST_SGL && is_wr;
  assign ee_addr  = cur;
  assign ee_wdata = wbyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ALO; is_wr <= 1'b0;
      cur <= '0; ptr <= '0; base_l <= '0; off <= '0;
      cnt <= '0; wbyte <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rd_pend) begin
            st <= ST_SGL; is_wr <= 1'b0; cur <= addr_q;
          end else if (wr_pend) begin
            st <= ST_SGL; is_wr <= 1'b1; cur <= addr_q; wbyte <= data_q;
          end else if (bu_pend) begin
            st <= ST_BURST; ph <= PH_ALO; cur <= ptr; base_l <= base_q;
          end
        end
        ST_SGL: if (ee_done) begin
          st  <= ST_IDLE;
          ptr <= cur + 1'b1;
        end
        default: if (ee_done) begin
          cur <= cur + 1'b1;
          ptr <= cur + 1'b1;
          case (ph)
            PH_ALO: begin off[7:0] <= ee_rdata; ph <= PH_AHI; end
            PH_AHI: begin off <= rec_offset(ee_rdata[6:0], off[7:0]); ph <= PH_LEN; end
            PH_LEN: begin
              if (ee_rdata == 8'd0) st <= ST_IDLE;
              else begin cnt <= ee_rdata; ph <= PH_DAT; end
            end
            default: begin
              mem_we    <= 1'b1;
              mem_addr  <= burst_mem_addr(base_l, off);
              mem_wdata <= ee_rdata;
              off       <= off + 1'b1;
              cnt       <= cnt - 1'b1;
              if (cnt == 8'd1) ph <= PH_ALO;
            end
          endcase
        end
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_done) |=> (ee_req && $stable(ee_addr))); // R9
  AST_ONE_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fin, wr_fin, bu_fin})); // R9
  AST_START_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_req) |-> $past(rd_pend || wr_pend || bu_pend)); // R9
  AST_MEMWE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> st == ST_BURST); // R7
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |-> (ee_req && wr_pend)); // R3
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
  import eeb_pkg::*;
#(
  parameter int HW    = 32,
  parameter int EE_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [2:0]       hw_sel,
  input  logic [HW-1:0]    hw_wdata,
  input  logic [2:0]       hr_sel,
  output logic [HW-1:0]    hr_data,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  input  logic [7:0]       ee_rdata,
  input  logic             ee_done,
  output logic             mem_we,
  output logic [23:0]      mem_addr,
  output logic [7:0]       mem_wdata
);
  logic              rd_fin, wr_fin, bu_fin;
  logic [7:0]        rd_byte;
  logic              rd_pend, wr_pend, bu_pend;
  logic [EE_AW-1:0]  addr_q;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base_q;

  eeb_hostregs #(.HW(HW), .EE_AW(EE_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
    .hr_sel(hr_sel), .hr_data(hr_data), .rd_fin(rd_fin), .wr_fin(wr_fin),
    .bu_fin(bu_fin), .rd_byte(rd_byte), .rd_pend(rd_pend), .wr_pend(wr_pend),
    .bu_pend(bu_pend), .addr_q(addr_q), .data_q(data_q), .base_q(base_q));

  eeb_engine #(.EE_AW(EE_AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend), .wr_pend(wr_pend),
    .bu_pend(bu_pend), .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
    .rd_fin(rd_fin), .wr_fin(wr_fin), .bu_fin(bu_fin), .rd_byte(rd_byte),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .ee_done(ee_done), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ee_req && !mem_we)); // R1
endmodule

// File: tb/sim_eeprom_loader.sv
module sim_eeprom_loader;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_en = 1'b0;
  logic [2:0] hw_sel = '0, hr_sel = '0;
  logic [31:0] hw_wdata = '0, hr_data;
  logic ee_req, ee_we, ee_done, mem_we;
  logic [AW-1:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata, mem_wdata;
  logic [23:0] mem_addr;

  always #4 clk = ~clk;

  eeprom_loader #(.HW(32), .EE_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
    .hr_sel(hr_sel), .hr_data(hr_data), .ee_req(ee_req), .ee_we(ee_we),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_done(ee_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  logic [7:0] rom [0:(1<<AW)-1];
  logic [1:0] lat;
  int acc_n = 0, mw_n = 0;
  logic acc_we [0:63];
  logic [AW-1:0] acc_a [0:63];
  logic [7:0] acc_d [0:63];
  logic [23:0] mw_a [0:63];
  logic [7:0] mw_d [0:63];
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lat <= '0; ee_done <= 1'b0; ee_rdata <= '0;
    end else begin
      ee_done <= 1'b0;
      if (ee_req && !ee_done) begin
        if (lat == 2'd2) begin
          lat <= '0; ee_done <= 1'b1;
          if (!ee_we) ee_rdata <= rom[ee_addr];
          if (acc_n < 64) begin
            acc_we[acc_n] <= ee_we; acc_a[acc_n] <= ee_addr; acc_d[acc_n] <= ee_wdata;
          end
          acc_n <= acc_n + 1;
        end else lat <= lat + 1'b1;
      end else lat <= '0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      if (mw_n < 64) begin mw_a[mw_n] <= mem_addr; mw_d[mw_n] <= mem_wdata; end
      mw_n <= mw_n + 1;
    end
  end

  function automatic logic [23:0] exp_ma(input int base, input int field);
    return 24'((base % 512) * 32768 + (field % 32768));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_sel = sel; hw_wdata = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    hr_sel = sel; #1; d = hr_data;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] c, b;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(3'd0, c); rd(3'd4, b);
      if (c == 0 && b == 0) return;
    end
    checks++; errors++;
    $display("FAIL %s: operation never finished", req);
  endtask

  task automatic put(input int a, input logic [7:0] v);
    rom[a] = v;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int m;
    for (int i = 0; i < (1 << AW); i++) rom[i] = 8'h00;
    // burst image at 0: two records, then a terminator
    put(0, 8'h05); put(1, 8'h80); put(2, 8'h03); put(3, 8'h11); put(4, 8'h22); put(5, 8'h33);
    put(6, 8'hFF); put(7, 8'h7F); put(8, 8'h02); put(9, 8'h44); put(10, 8'h55);
    put(100, 8'h9C);
    put(101, 8'h10); put(102, 8'h00); put(103, 8'h01); put(104, 8'h66);
    put(108, 8'h20); put(109, 8'h00); put(110, 8'h01); put(111, 8'h77);
    put(300, 8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 burst bit", v, 0);
    chk("R1 ee_req", ee_req, 0);
    chk("R1 mem_we", mem_we, 0);

    // R5 R7 R8: burst right after reset
    wr(3'd3, 32'h1A5);
    wr(3'd4, 32'h1);
    wait_idle("R7 burst 1");
    chk("R5 first fetch at 0", acc_a[0], 0);
    chk("R7 bytes consumed", acc_n, 14);
    chk("R8 write count", mw_n, 5);
    chk("R8 addr0 msb ignored", mw_a[0], exp_ma(32'h1A5, 32'h8005));
    chk("R8 data0", mw_d[0], 8'h11);
    chk("R8 addr2", mw_a[2], exp_ma(32'h1A5, 32'h8007));
    chk("R8 data2", mw_d[2], 8'h33);
    chk("R8 addr top", mw_a[3], exp_ma(32'h1A5, 32'h7FFF));
    chk("R8 wrap in 15 bits", mw_a[4], exp_ma(32'h1A5, 32'h7FFF + 1));
    chk("R8 data4", mw_d[4], 8'h55);
    rd(3'd4, v); chk("R7 burst bit clear", v, 0);

    // R2: single read
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h2);
    wait_idle("R2 read");
    rd(3'd2, v); chk("R2 data byte", v, 32'h9C);
    chk("R2 read addr", acc_a[14], 100);
    chk("R2 is read", acc_we[14], 0);

    // R6: burst continues after single access, then after burst
    wr(3'd3, 32'h3);
    wr(3'd4, 32'h1);
    wait_idle("R6 burst 2");
    chk("R6 start after read", acc_a[15], 101);
    chk("R8 burst2 addr", mw_a[5], exp_ma(3, 32'h10));
    chk("R8 burst2 data", mw_d[5], 8'h66);
    wr(3'd4, 32'h1);
    wait_idle("R6 burst 3");
    chk("R6 start after burst", acc_a[22], 108);
    chk("R6 burst3 addr", mw_a[6], exp_ma(3, 32'h20));
    chk("R6 burst3 data", mw_d[6], 8'h77);

    // R3 R4: single write, data register narrow
    wr(3'd1, 32'd200);
    wr(3'd2, 32'h1C3);
    rd(3'd2, v); chk("R4 data reg 8 bits", v, 32'hC3);
    wr(3'd0, 32'h1);
    wait_idle("R3 write");
    chk("R3 is write", acc_we[29], 1);
    chk("R3 write addr", acc_a[29], 200);
    chk("R3 write byte", acc_d[29], 8'hC3);

    // R9 R10: overlapping requests
    wr(3'd1, 32'd300);
    m = acc_n;
    wr(3'd0, 32'h2);
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R10 zero does not cancel", v, 3);
    wr(3'd4, 32'h1);
    wait_idle("R9 overlap");
    chk("R9 access count", acc_n - m, 5);
    chk("R9 first is read", {acc_we[m], 6'b0, acc_a[m]}, {1'b0, 6'b0, 10'd300});
    chk("R9 second is write", {acc_we[m+1], 6'b0, acc_a[m+1]}, {1'b1, 6'b0, 10'd300});
    chk("R9 write took read byte", acc_d[m+1], 8'h5A);
    chk("R9 burst last", {acc_we[m+2], 6'b0, acc_a[m+2]}, {1'b0, 6'b0, 10'd301});
    chk("R9 burst end addr", acc_a[m+4], 303);
    chk("R9 no mem writes", mw_n, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule